// File: doc/BRIEF.md
# In-Order Retirement Queue with Precise Flush

This block is the retirement queue of a speculative out-of-order core. When the front end issues an instruction, the queue takes a free slot at its tail. It returns that slot number as the instruction's tag. Execution units report finished results on a shared result bus, keyed by that tag and in any order. The queue records each result against its slot and touches no architectural state when it does so. A completed slot can also serve a source operand to a consumer whose register file does not yet hold that value.

Slots leave the queue only from the head, in program order, and only once their result has arrived. At the head, an arithmetic result becomes a register-file write, a store gets permission to write memory, and a branch is resolved. A branch that turns out to be mispredicted, or an instruction that carried a fault, is acted on only at the head. Either one empties the whole queue at once and raises a restart or fault indication, so the core's state stays exact.

Top module: `retire_queue`

## Requirements
- R1: Each accepted issue receives as its tag the current tail slot index. Tags run 0, 1, 2, … and wrap from DEPTH-1 back to 0.
- R2: `issue_ready` is low while DEPTH slots are occupied, and an issue request offered then allocates nothing.
- R3: An issue and a retirement in the same cycle leave the occupancy unchanged.
- R4: A completion marks its slot finished and stores its value and flags, and it may arrive in any order. No commit output is raised while the head slot is unfinished.
- R5: A slot retires only when it is the head and finished. A finished arithmetic slot (kind 2'b00) at the head drives `rf_we` high with its destination and value, and the slot is then freed.
- R6: A finished store slot (kind 2'b01) at the head raises `st_release` and never `rf_we`.
- R7: A finished branch slot (kind 2'b10) at the head raises `br_resolve`. If it was marked mispredicted, it also raises `restart`, and on the next edge every slot is discarded and the tail returns to 0.
- R8: A fault flag recorded against a slot has no visible effect until that slot is the finished head. Then `exc_raise` is high, no write or release is made, and every slot is discarded.
- R9: A lookup by tag reports `fwd_hit` with the stored value only when that slot is occupied and finished.
- R10: A completion whose tag names an unoccupied slot is ignored. A later issue into that slot finds it unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Issue request |
| issue_kind | input | 2 | 00 arithmetic, 01 store, 10 branch |
| issue_dest | input | REG_W | Destination register |
| issue_ready | output | 1 | A slot can be taken this cycle |
| issue_tag | output | TAG_W | Tag given to the issued instruction |
| cmpl_valid | input | 1 | Result-bus broadcast |
| cmpl_tag | input | TAG_W | Slot of the finished instruction |
| cmpl_value | input | DATA_W | Result value |
| cmpl_mispredict | input | 1 | Branch was mispredicted |
| cmpl_exception | input | 1 | Instruction faulted |
| fwd_tag | input | TAG_W | Operand lookup slot |
| fwd_hit | output | 1 | Looked-up slot holds a finished value |
| fwd_value | output | DATA_W | Looked-up value |
| rf_we | output | 1 | Register-file write at retirement |
| rf_waddr | output | REG_W | Write register |
| rf_wdata | output | DATA_W | Write value |
| st_release | output | 1 | Store may write memory |
| br_resolve | output | 1 | Branch retires |
| restart | output | 1 | Misprediction restart, queue emptied |
| exc_raise | output | 1 | Precise fault, queue emptied |
| retire_tag | output | TAG_W | Head slot index |

## Verification
Issue and retirement can happen in the same cycle. The bench provokes this by completing the head while the queue holds DEPTH-1 slots and presenting a new issue in the cycle the head retires. It then judges the outcome by the register write seen that cycle and by the fact that exactly one further issue fills the queue. The bench also overlaps completion with retirement, by completing younger slots in reverse order while the head stays unfinished, and checks that no commit output appears until the head finishes.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2,
    K_RSVD   = 2'd3
  } kind_e;
endpackage

// File: rtl/rq_ptr_ctrl.sv
module rq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             retire,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic             full
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == LAST) ? '0 : p + TAG_W'(1);
  endfunction

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (retire) head_d = bump(head_q);
      if (alloc)  tail_d = bump(tail_q);
      cnt_d = cnt_q + CNT_W'(alloc) - CNT_W'(retire);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign full = (cnt_q == CNT_W'(DEPTH));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r2_alloc_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);
  a_r5_retire_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> cnt_q != '0);
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && retire && !flush) |=> cnt_q == $past(cnt_q));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0) && (head_q == tail_q));
endmodule

// File: rtl/rq_entry_array.sv
module rq_entry_array
  import rq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [TAG_W-1:0]  alloc_idx,
  input  kind_e             alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              cmpl_valid,
  input  logic [TAG_W-1:0]  cmpl_tag,
  input  logic [DATA_W-1:0] cmpl_value,
  input  logic              cmpl_mis,
  input  logic              cmpl_exc,
  input  logic              retire,
  input  logic [TAG_W-1:0]  head,
  input  logic              flush,
  input  logic [TAG_W-1:0]  fwd_tag,
  output logic              hd_valid,
  output logic              hd_done,
  output kind_e             hd_kind,
  output logic [REG_W-1:0]  hd_dest,
  output logic [DATA_W-1:0] hd_value,
  output logic              hd_mis,
  output logic              hd_exc,
  output logic              fwd_ok,
  output logic [DATA_W-1:0] fwd_val
);
  typedef struct packed {
    logic              valid;
    logic              done;
    kind_e             kind;
    logic [REG_W-1:0]  dest;
    logic [DATA_W-1:0] value;
    logic              mis;
    logic              exc;
  } slot_t;

  slot_t slot_q [DEPTH];
  slot_t slot_d [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [TAG_W-1:0] IDX = TAG_W'(g);
    logic hit_alloc, hit_cmpl, hit_retire;

    assign hit_alloc  = alloc && (alloc_idx == IDX);
    assign hit_cmpl   = cmpl_valid && (cmpl_tag == IDX) && slot_q[g].valid;
    assign hit_retire = retire && (head == IDX);

    always_comb begin
      slot_d[g] = slot_q[g];
      if (flush) begin
        slot_d[g].valid = 1'b0;
        slot_d[g].done  = 1'b0;
      end else begin
        if (hit_retire) begin
          slot_d[g].valid = 1'b0;
          slot_d[g].done  = 1'b0;
        end
        if (hit_cmpl) begin
          slot_d[g].done  = 1'b1;
          slot_d[g].value = cmpl_value;
          slot_d[g].mis   = cmpl_mis;
          slot_d[g].exc   = cmpl_exc;
        end
        if (hit_alloc) begin
          slot_d[g].valid = 1'b1;
          slot_d[g].done  = 1'b0;
          slot_d[g].kind  = alloc_kind;
          slot_d[g].dest  = alloc_dest;
          slot_d[g].value = '0;
          slot_d[g].mis   = 1'b0;
          slot_d[g].exc   = 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else        slot_q[g] <= slot_d[g];
    end

    a_r4_done_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q[g].done |-> slot_q[g].valid);
    a_r10_ignore_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_valid && cmpl_tag == IDX && !slot_q[g].valid) |=> !slot_q[g].done);
  end

  assign hd_valid = slot_q[head].valid;
  assign hd_done  = slot_q[head].done;
  assign hd_kind  = slot_q[head].kind;
  assign hd_dest  = slot_q[head].dest;
  assign hd_value = slot_q[head].value;
  assign hd_mis   = slot_q[head].mis;
  assign hd_exc   = slot_q[head].exc;
  assign fwd_ok   = slot_q[fwd_tag].valid && slot_q[fwd_tag].done;
  assign fwd_val  = slot_q[fwd_tag].value;
endmodule

// File: rtl/rq_retire.sv
module rq_retire
  import rq_pkg::*;
(
  input  logic  hd_valid,
  input  logic  hd_done,
  input  kind_e hd_kind,
  input  logic  hd_mis,
  input  logic  hd_exc,
  output logic  retire,
  output logic  flush,
  output logic  rf_we,
  output logic  st_release,
  output logic  br_resolve,
  output logic  restart,
  output logic  exc_raise
);
  logic ready_head, clean;

  always_comb begin
    ready_head = hd_valid && hd_done;
    clean      = ready_head && !hd_exc;
    exc_raise  = ready_head && hd_exc;
    rf_we      = clean && (hd_kind == K_ALU);
    st_release = clean && (hd_kind == K_STORE);
    br_resolve = clean && (hd_kind == K_BRANCH);
    restart    = br_resolve && hd_mis;
    flush      = exc_raise || restart;
    retire     = ready_head && !flush;
  end
endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import rq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [1:0]        issue_kind,
  input  logic [REG_W-1:0]  issue_dest,
  output logic              issue_ready,
  output logic [TAG_W-1:0]  issue_tag,
  input  logic              cmpl_valid,
  input  logic [TAG_W-1:0]  cmpl_tag,
  input  logic [DATA_W-1:0] cmpl_value,
  input  logic              cmpl_mispredict,
  input  logic              cmpl_exception,
  input  logic [TAG_W-1:0]  fwd_tag,
  output logic              fwd_hit,
  output logic [DATA_W-1:0] fwd_value,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              st_release,
  output logic              br_resolve,
  output logic              restart,
  output logic              exc_raise,
  output logic [TAG_W-1:0]  retire_tag
);
  logic             alloc, retire, flush, full;
  logic [TAG_W-1:0] head, tail;
  logic             hd_valid, hd_done, hd_mis, hd_exc;
  kind_e            hd_kind;
  logic [REG_W-1:0] hd_dest;
  logic [DATA_W-1:0] hd_value;

  assign issue_ready = !full && !flush;
  assign alloc       = issue_valid && issue_ready;
  assign issue_tag   = tail;
  assign retire_tag  = head;
  assign rf_waddr    = hd_dest;
  assign rf_wdata    = hd_value;

  rq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .retire(retire), .flush(flush),
    .head(head), .tail(tail), .full(full)
  );

  rq_entry_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .alloc(alloc), .alloc_idx(tail), .alloc_kind(kind_e'(issue_kind)),
    .alloc_dest(issue_dest),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_value(cmpl_value),
    .cmpl_mis(cmpl_mispredict), .cmpl_exc(cmpl_exception),
    .retire(retire), .head(head), .flush(flush), .fwd_tag(fwd_tag),
    .hd_valid(hd_valid), .hd_done(hd_done), .hd_kind(hd_kind),
    .hd_dest(hd_dest), .hd_value(hd_value), .hd_mis(hd_mis), .hd_exc(hd_exc),
    .fwd_ok(fwd_hit), .fwd_val(fwd_value)
  );

  rq_retire u_ret (
    .hd_valid(hd_valid), .hd_done(hd_done), .hd_kind(hd_kind),
    .hd_mis(hd_mis), .hd_exc(hd_exc),
    .retire(retire), .flush(flush), .rf_we(rf_we), .st_release(st_release),
    .br_resolve(br_resolve), .restart(restart), .exc_raise(exc_raise)
  );

  a_r5_write_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> hd_valid && hd_done);
  a_r6_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
    st_release |-> !rf_we);
  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    exc_raise |-> !rf_we && !st_release && !br_resolve);
  a_r7_restart_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> issue_tag == '0 && !fwd_hit);
  a_r1_tag_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !flush && tail != TAG_W'(DEPTH - 1)) |=> issue_tag == $past(issue_tag) + TAG_W'(1));
endmodule

// File: tb/retire_queue_tb.sv
module retire_queue_tb;
  localparam int DEPTH = 8, DATA_W = 32, REG_W = 5, TAG_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic issue_valid; logic [1:0] issue_kind; logic [REG_W-1:0] issue_dest;
  logic issue_ready; logic [TAG_W-1:0] issue_tag;
  logic cmpl_valid; logic [TAG_W-1:0] cmpl_tag; logic [DATA_W-1:0] cmpl_value;
  logic cmpl_mispredict, cmpl_exception;
  logic [TAG_W-1:0] fwd_tag; logic fwd_hit; logic [DATA_W-1:0] fwd_value;
  logic rf_we; logic [REG_W-1:0] rf_waddr; logic [DATA_W-1:0] rf_wdata;
  logic st_release, br_resolve, restart, exc_raise; logic [TAG_W-1:0] retire_tag;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  retire_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_dut (.*);

  // row: kind[40:39] dest[38:34] value[33:2] mispredict[1] exception[0]
  localparam logic [40:0] VEC [6] = '{
    {2'd0, 5'd3,  32'h0000_0011, 1'b0, 1'b0},
    {2'd1, 5'd0,  32'h0000_0022, 1'b0, 1'b0},
    {2'd0, 5'd7,  32'h0000_0033, 1'b0, 1'b0},
    {2'd2, 5'd0,  32'h0000_0000, 1'b0, 1'b0},
    {2'd0, 5'd9,  32'h0000_0044, 1'b0, 1'b0},
    {2'd0, 5'd1,  32'h0000_0055, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    issue_valid = 0; cmpl_valid = 0; cmpl_mispredict = 0; cmpl_exception = 0;
  endtask

  task automatic drive_issue(input logic [1:0] k, input logic [4:0] d);
    issue_valid = 1; issue_kind = k; issue_dest = d;
  endtask

  task automatic drive_cmpl(input logic [2:0] t, input logic [31:0] v,
                            input logic m, input logic e);
    cmpl_valid = 1; cmpl_tag = t; cmpl_value = v; cmpl_mispredict = m; cmpl_exception = e;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); issue_kind = 0; issue_dest = 0; cmpl_tag = 0; cmpl_value = 0; fwd_tag = 0;
    #22;
    chk("R1 reset tag", 32'(issue_tag), 0);
    chk("R2 reset ready", 32'(issue_ready), 1);
    chk("R5 reset no write", 32'(rf_we), 0);
    chk("R9 reset no hit", 32'(fwd_hit), 0);
    @(negedge clk); rst_n = 1;

    // vector walk: issue all rows (R1)
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); idle(); drive_issue(VEC[i][40:39], VEC[i][38:34]); #1;
      chk("R1 issue tag", 32'(issue_tag), i);
    end
    // complete in reverse order (R4), head stays unfinished until last
    for (int i = 5; i >= 0; i--) begin
      @(negedge clk); idle();
      drive_cmpl(3'(i), VEC[i][33:2], VEC[i][1], VEC[i][0]);
      fwd_tag = 3'd0; #1;
      chk("R4 no commit before head done",
          32'({rf_we, st_release, br_resolve, restart, exc_raise}), 0);
      chk("R9 unfinished lookup misses", 32'(fwd_hit), 0);
    end
    // retire in program order
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); idle(); fwd_tag = 3'(i); #1;
      chk("R9 forward hit", 32'(fwd_hit), 1);
      chk("R9 forward value", fwd_value, VEC[i][33:2]);
      chk("R5 retire tag", 32'(retire_tag), i);
      chk("R5 rf write", 32'(rf_we), 32'(VEC[i][40:39] == 2'd0));
      if (VEC[i][40:39] == 2'd0) begin
        chk("R5 rf addr", 32'(rf_waddr), 32'(VEC[i][38:34]));
        chk("R5 rf data", rf_wdata, VEC[i][33:2]);
      end
      chk("R6 store release", 32'(st_release), 32'(VEC[i][40:39] == 2'd1));
      chk("R7 branch resolve", 32'(br_resolve), 32'(VEC[i][40:39] == 2'd2));
      chk("R7 no restart", 32'(restart), 0);
    end
    @(negedge clk); idle(); #1;
    chk("R5 drained no write", 32'(rf_we), 0);

    // fill to capacity (R2), tags wrap 6,7,0..5 (R1)
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); idle(); drive_issue(2'd0, 5'(10 + i)); #1;
      chk("R1 wrapped tag", 32'(issue_tag), (6 + i) % DEPTH);
    end
    @(negedge clk); idle(); drive_issue(2'd0, 5'd31); #1;
    chk("R2 full not ready", 32'(issue_ready), 0);
    chk("R2 tail held", 32'(issue_tag), 6);
    @(negedge clk); idle(); drive_cmpl(3'd6, 32'hA6, 0, 0);
    @(negedge clk); idle(); #1;
    chk("R5 head write while full", 32'(rf_we), 1);
    chk("R5 head dest", 32'(rf_waddr), 10);
    chk("R2 stall refused entry", 32'(issue_ready), 0);
    drive_cmpl(3'd7, 32'hA7, 0, 0);
    @(negedge clk); idle(); #1;
    chk("R2 ready after retire", 32'(issue_ready), 1);
    // simultaneous issue and retire (R3)
    drive_issue(2'd0, 5'd20); #1;
    chk("R3 retire same cycle", 32'(rf_we), 1);
    chk("R3 retire data", rf_wdata, 32'hA7);
    @(negedge clk); idle(); #1;
    chk("R3 one slot still free", 32'(issue_ready), 1);
    drive_issue(2'd0, 5'd21);
    @(negedge clk); idle(); #1;
    chk("R3 full after one more", 32'(issue_ready), 0);

    // fault on a non-head slot stays hidden (R8)
    drive_cmpl(3'd1, 32'hB1, 0, 1);
    @(negedge clk); idle(); #1;
    chk("R8 non-head fault hidden", 32'(exc_raise), 0);
    drive_cmpl(3'd0, 32'hB0, 0, 0);
    @(negedge clk); idle(); #1;
    chk("R8 older slot retires", 32'(rf_we), 1);
    chk("R8 still hidden", 32'(exc_raise), 0);
    @(negedge clk); #1;
    chk("R8 fault at head", 32'(exc_raise), 1);
    chk("R8 no write on fault", 32'(rf_we), 0);
    @(negedge clk); fwd_tag = 3'd0; #1;
    chk("R8 queue emptied tag", 32'(issue_tag), 0);
    chk("R8 queue emptied ready", 32'(issue_ready), 1);
    chk("R8 exc cleared", 32'(exc_raise), 0);

    // mispredicted branch (R7)
    drive_issue(2'd2, 5'd0);
    @(negedge clk); drive_issue(2'd0, 5'd4);
    @(negedge clk); drive_issue(2'd0, 5'd5);
    @(negedge clk); idle(); drive_cmpl(3'd1, 32'h77, 0, 0);
    @(negedge clk); idle(); drive_cmpl(3'd0, 32'h0, 1, 0);
    @(negedge clk); idle(); fwd_tag = 3'd1; #1;
    chk("R7 restart", 32'(restart), 1);
    chk("R7 resolve", 32'(br_resolve), 1);
    chk("R7 no write", 32'(rf_we), 0);
    chk("R9 younger hit before flush", 32'(fwd_hit), 1);
    @(negedge clk); #1;
    chk("R7 younger discarded", 32'(fwd_hit), 0);
    chk("R7 tail rewound", 32'(issue_tag), 0);
    chk("R7 restart cleared", 32'(restart), 0);

    // completion to an empty slot (R10)
    drive_cmpl(3'd3, 32'hDEAD, 0, 0);
    @(negedge clk); idle();
    for (int i = 0; i < 4; i++) begin
      drive_issue(2'd0, 5'(i)); @(negedge clk);
    end
    idle(); fwd_tag = 3'd3; #1;
    chk("R10 stray completion ignored", 32'(fwd_hit), 0);
    chk("R10 no commit", 32'(rf_we), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule